// File: doc/BRIEF.md
# Load/Store Address and Extension Unit

This unit sits between an execution stage and a word-wide synchronous data memory. For each accepted request it forms an effective byte address from a 32-bit base value plus an 8-bit unsigned offset. The offset is first multiplied by the access width: 1 for bytes, 2 for halfwords and 4 for words. It then issues a single memory access with per-lane byte enables and returns the formatted result.

Load data is taken from the lanes the address selects and widened to 32 bits. Byte loads are always zero-filled. Halfword loads are zero-filled or sign-extended from bit 15, depending on a signed selector. Word loads are returned whole.

Stores place the store data in the addressed lanes and enable only those lanes. No extension is applied to store data.

A configuration pin selects the byte order. Low means little endian, which is the default, and high means big endian. The pin is sampled when a request is accepted.

A misaligned halfword or word address suppresses the memory access and is reported as an error response.

The request side is a valid/ready stream. A request is accepted in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while no access is outstanding. A requester that sees `req_ready` low must hold its request.

The response side is a one-cycle `rsp_valid` pulse with no back-pressure. The consumer must take the response in the cycle it appears.

The memory side uses the following handshake:
- `mem_req` pulses for one cycle, and the address, enables and write data stay stable until the response.
- The memory answers a load with `mem_rvalid` and a store with `mem_ack`, no earlier than the cycle in which `mem_req` is high.

Top module: `lsu_addr_ext`

## Requirements
- R1: The effective address is `req_base + (req_ofs << s)`, taken modulo 2^32. Here s is 0 for byte (`req_size`=0), 1 for halfword (`req_size`=1) and 2 for word (`req_size`=2; code 3 also behaves as word). `mem_addr` carries bits [31:2] of that address.
- R2: A halfword request with address bit 0 set, or a word request with address bits [1:0] nonzero, never raises `mem_req`. In the cycle after acceptance it gives `rsp_valid`=1 and `rsp_err`=1 with `rsp_data`=0. Byte requests are never misaligned.
- R3: A byte load returns the addressed byte in bits [7:0] with bits [31:8] zero, whatever `req_signed` is. In little endian, byte address offset k (address bits [1:0]) comes from `mem_rdata[8k+7:8k]`.
- R4: A halfword load returns 16 bits in [15:0]. Bits [31:16] are copies of bit 15 when `req_signed`=1 and zero when `req_signed`=0. In little endian, address bit 1 = h selects `mem_rdata[16h+15:16h]`.
- R5: A word load returns `mem_rdata` unchanged in both byte orders.
- R6: With `cfg_big_endian`=1 at acceptance, byte offset k maps to lane 3-k, and the byte at the lower address is the more significant one. A big-endian halfword at address bit 1 = 0 therefore comes from `mem_rdata[31:16]`. A change of `cfg_big_endian` while an access is outstanding has no effect on it.
- R7: A store drives `mem_we`=1. `mem_be` has exactly the lanes of the addressed bytes set: lane L is bit L and covers `mem_wdata[8L+7:8L]`, with lane mapping as in R3 and R6. Those lanes carry the store data bytes in the selected byte order.
- R8: `mem_req` rises in the cycle after acceptance and lasts exactly one cycle. `rsp_valid` is high for exactly one cycle, in the cycle after the memory's `mem_rvalid` (load) or `mem_ack` (store). For a load, `rsp_data` is formatted from the `mem_rdata` sampled with `mem_rvalid`.
- R9: `mem_rvalid` and `mem_ack` produce no response when no access is outstanding. `mem_ack` is ignored during a load and `mem_rvalid` during a store.
- R10: `req_ready` is low from the cycle after an aligned request is accepted until the response cycle, in which it is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_big_endian | input | 1 | Byte order: 0 little endian, 1 big endian |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_store | input | 1 | 1 store, 0 load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_signed | input | 1 | Sign-extend halfword loads |
| req_base | input | 32 | Base register value |
| req_ofs | input | 8 | Unsigned offset before scaling |
| req_wdata | input | 32 | Store data, right-aligned |
| mem_req | output | 1 | One-cycle memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 30 | Memory word address |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Memory write data |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 32 | Memory read data |
| mem_ack | input | 1 | Memory store acknowledge |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Response is an alignment error |
| rsp_data | output | 32 | Extended load result, zero for stores and errors |

## Verification
The bench runs every lane position for bytes and both halves for halfwords in each byte order. Negative halfword patterns catch a design that extends from the wrong bit or ignores the signed selector, and a signed byte request catches one that sign-extends bytes. Large offsets, plus a base that wraps past the top of the address space, expose a missing or wrong offset scale. Misaligned halfwords and words must produce an error and no memory strobe, and a design that still strobed the memory would corrupt storage. Stray acknowledges, read-valids of the wrong kind and an endian flip during an outstanding access catch a design that finishes early or reformats with live configuration.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int DATA_W    = 32;
  localparam int LANES     = DATA_W / 8;
  localparam int LANE_BITS = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRD3 = 2'd3
  } acc_size_e;

  // byte count minus one for an access size
  function automatic logic [LANE_BITS-1:0] size_mask(acc_size_e s);
    case (s)
      SZ_BYTE: size_mask = 2'd0;
      SZ_HALF: size_mask = 2'd1;
      default: size_mask = 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen import lsu_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 8
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFS_W-1:0]  ofs,
  input  acc_size_e         size,
  output logic [ADDR_W-1:0] addr,
  output logic              misalign
);
  localparam int PAD_W = ADDR_W - OFS_W;

  logic [ADDR_W-1:0] ofs_ext;
  logic [ADDR_W-1:0] scaled;

  assign ofs_ext = {{PAD_W{1'b0}}, ofs};

  always_comb begin
    case (size)
      SZ_BYTE: scaled = ofs_ext;
      SZ_HALF: scaled = ofs_ext << 1;
      default: scaled = ofs_ext << 2;
    endcase
  end

  assign addr = base + scaled;

  always_comb begin
    case (size)
      SZ_BYTE: misalign = 1'b0;
      SZ_HALF: misalign = addr[0];
      default: misalign = |addr[1:0];
    endcase
  end
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes import lsu_pkg::*; (
  input  logic [LANE_BITS-1:0] addr_lo,
  input  acc_size_e            size,
  input  logic                 big,
  input  logic [DATA_W-1:0]    wdata,
  output logic [LANES-1:0]     be,
  output logic [DATA_W-1:0]    lane_data
);
  logic [LANE_BITS-1:0] nm1;
  assign nm1 = size_mask(size);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_BITS-1:0] la;   // byte address offset held by this lane
    logic [LANE_BITS-1:0] rel;  // position of that byte inside the access group
    logic [LANE_BITS-1:0] idx;  // byte of the store data placed here

    always_comb begin
      la  = big ? ~LANE_BITS'(l) : LANE_BITS'(l);
      rel = la & nm1;
      idx = big ? (nm1 - rel) : rel;
      case (size)
        SZ_BYTE: be[l] = (la == addr_lo);
        SZ_HALF: be[l] = (la[1] == addr_lo[1]);
        default: be[l] = 1'b1;
      endcase
      lane_data[8*l +: 8] = wdata[8*idx +: 8];
    end
  end
endmodule

// File: rtl/lsu_load_fmt.sv
module lsu_load_fmt import lsu_pkg::*; (
  input  logic [DATA_W-1:0]    rdata,
  input  logic [LANE_BITS-1:0] addr_lo,
  input  acc_size_e            size,
  input  logic                 sgn,
  input  logic                 big,
  output logic [DATA_W-1:0]    result
);
  logic [LANE_BITS-1:0] nm1;
  logic [LANE_BITS-1:0] grp_lo;
  logic [7:0]           vb [LANES];  // value bytes, index 0 least significant

  assign nm1    = size_mask(size);
  assign grp_lo = addr_lo & ~nm1;

  for (genvar j = 0; j < LANES; j++) begin : g_vbyte
    logic [LANE_BITS-1:0] aj;
    logic [LANE_BITS-1:0] lane;
    always_comb begin
      aj    = grp_lo + (big ? (nm1 - LANE_BITS'(j)) : LANE_BITS'(j));
      lane  = big ? ~aj : aj;
      vb[j] = rdata[8*lane +: 8];
    end
  end

  always_comb begin
    case (size)
      SZ_BYTE: result = {24'h0, vb[0]};
      SZ_HALF: result = {{16{sgn & vb[1][7]}}, vb[1], vb[0]};
      default: result = {vb[3], vb[2], vb[1], vb[0]};
    endcase
  end
endmodule

// File: rtl/lsu_addr_ext.sv
module lsu_addr_ext import lsu_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_big_endian,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_store,
  input  logic [1:0]               req_size,
  input  logic                     req_signed,
  input  logic [ADDR_W-1:0]        req_base,
  input  logic [OFS_W-1:0]         req_ofs,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     mem_req,
  output logic                     mem_we,
  output logic [ADDR_W-LANE_BITS-1:0] mem_addr,
  output logic [LANES-1:0]         mem_be,
  output logic [DATA_W-1:0]        mem_wdata,
  input  logic                     mem_rvalid,
  input  logic [DATA_W-1:0]        mem_rdata,
  input  logic                     mem_ack,
  output logic                     rsp_valid,
  output logic                     rsp_err,
  output logic [DATA_W-1:0]        rsp_data
);
  typedef enum logic {ST_IDLE, ST_WAIT} st_e;

  st_e                  st;
  acc_size_e            in_size;
  logic [ADDR_W-1:0]    eff_addr;
  logic                 mis;
  logic [LANES-1:0]     be_c;
  logic [DATA_W-1:0]    wd_c;
  logic [DATA_W-1:0]    ld_c;
  logic                 accept;
  logic                 done;

  logic [LANE_BITS-1:0] q_lo;
  acc_size_e            q_size;
  logic                 q_sgn;
  logic                 q_big;

  assign in_size   = acc_size_e'(req_size);
  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign done      = (st == ST_WAIT) && (mem_we ? mem_ack : mem_rvalid);

  lsu_agen #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) agen_i (
    .base(req_base), .ofs(req_ofs), .size(in_size),
    .addr(eff_addr), .misalign(mis)
  );

  lsu_store_lanes st_lanes_i (
    .addr_lo(eff_addr[LANE_BITS-1:0]), .size(in_size), .big(cfg_big_endian),
    .wdata(req_wdata), .be(be_c), .lane_data(wd_c)
  );

  lsu_load_fmt ld_fmt_i (
    .rdata(mem_rdata), .addr_lo(q_lo), .size(q_size), .sgn(q_sgn),
    .big(q_big), .result(ld_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
      q_lo      <= '0;
      q_size    <= SZ_BYTE;
      q_sgn     <= 1'b0;
      q_big     <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_data  <= '0;
    end else begin
      mem_req   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      if (accept) begin
        if (mis) begin
          rsp_valid <= 1'b1;
          rsp_err   <= 1'b1;
          rsp_data  <= '0;
        end else begin
          st        <= ST_WAIT;
          mem_req   <= 1'b1;
          mem_we    <= req_store;
          mem_addr  <= eff_addr[ADDR_W-1:LANE_BITS];
          mem_be    <= req_store ? be_c : {LANES{1'b1}};
          mem_wdata <= req_store ? wd_c : '0;
          q_lo      <= eff_addr[LANE_BITS-1:0];
          q_size    <= in_size;
          q_sgn     <= req_signed;
          q_big     <= cfg_big_endian;
        end
      end else if (done) begin
        st        <= ST_IDLE;
        rsp_valid <= 1'b1;
        rsp_data  <= mem_we ? '0 : ld_c;
      end
    end
  end

  // R8: the memory strobe never lasts two cycles
  assert_req_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R2: a misaligned request never reaches memory and reports an error
  assert_no_access_misalign_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mis) |=> (!mem_req && rsp_valid && rsp_err));

  // R10: no new request is taken while the strobe is out
  assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !req_ready);

  // R8: load data answer yields a response on the next cycle
  assert_load_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !mem_we && mem_rvalid) |=> (rsp_valid && !rsp_err));

  // R9: a store ignores read-valid until its acknowledge
  assert_store_ignores_rvalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && mem_we && !mem_ack) |=> !rsp_valid);

  // R3: byte load results carry no upper bits
  assert_byte_zero_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_err && !mem_we && q_size == SZ_BYTE) |-> (rsp_data[31:8] == 24'h0));

  // R7: a store byte access enables exactly one lane
  assert_byte_store_one_lane_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && q_size == SZ_BYTE) |-> ($countones(mem_be) == 1));
endmodule

// File: tb/lsu_addr_ext_tb_top.sv
`timescale 1ns/1ps
module lsu_addr_ext_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_big_endian = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_store = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic        req_signed = 1'b0;
  logic [31:0] req_base = '0;
  logic [7:0]  req_ofs = '0;
  logic [31:0] req_wdata = '0;
  logic        mem_req, mem_we;
  logic [29:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_data;

  int nchk = 0;
  int nerr = 0;

  always #2.5 clk = ~clk;

  lsu_addr_ext dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_big_endian(cfg_big_endian),
    .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
    .req_size(req_size), .req_signed(req_signed), .req_base(req_base),
    .req_ofs(req_ofs), .req_wdata(req_wdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_data(rsp_data)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // byte stored at byte offset a of a word, for a given byte order
  function automatic logic [7:0] byte_at(input logic [31:0] w, input int a, input logic big);
    int lane = big ? 3 - a : a;
    return w[8*lane +: 8];
  endfunction

  function automatic logic [31:0] model_load(input logic [31:0] addr, input int sz,
      input logic sgn, input logic big, input logic [31:0] rd);
    int n = 1 << sz;
    int a0 = int'(addr[1:0]);
    logic [31:0] v = '0;
    for (int k = 0; k < n; k++) begin
      if (big) v = (v << 8) | 32'(byte_at(rd, a0 + k, big));
      else     v = v | (32'(byte_at(rd, a0 + k, big)) << (8 * k));
    end
    if (sz == 1 && sgn && v[15]) v = v | 32'hFFFF_0000;
    return v;
  endfunction

  task automatic run_op(input string tag, input logic st, input logic [31:0] base,
      input logic [7:0] ofs, input int sz, input logic sgn, input logic big,
      input logic [31:0] wd, input logic [31:0] rd, input int lat,
      input logic spurious, input logic flip);
    logic [31:0] a;
    logic        mis;
    int          n;
    logic [3:0]  ebe;
    logic [31:0] ewd, mask;
    a   = base + (32'(ofs) << sz);
    n   = 1 << sz;
    mis = (sz == 1 && a[0]) || (sz == 2 && a[1:0] != 2'b00);
    @(negedge clk);
    chk("R10", {tag, " ready idle"}, 32'(req_ready), 32'd1);
    chk("R8", {tag, " no stray rsp"}, 32'(rsp_valid), 32'd0);
    req_store = st; req_base = base; req_ofs = ofs; req_size = 2'(sz);
    req_signed = sgn; req_wdata = wd; cfg_big_endian = big; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (mis) begin
      chk("R2", {tag, " err valid"}, 32'(rsp_valid), 32'd1);
      chk("R2", {tag, " err flag"}, 32'(rsp_err), 32'd1);
      chk("R2", {tag, " err data"}, rsp_data, 32'd0);
      chk("R2", {tag, " no mem_req"}, 32'(mem_req), 32'd0);
      @(negedge clk);
      chk("R2", {tag, " no late mem_req"}, 32'(mem_req), 32'd0);
      chk("R8", {tag, " single rsp"}, 32'(rsp_valid), 32'd0);
      return;
    end
    chk("R8", {tag, " mem_req"}, 32'(mem_req), 32'd1);
    chk("R1", {tag, " mem_addr"}, 32'(mem_addr), 32'(a[31:2]));
    chk("R7", {tag, " mem_we"}, 32'(mem_we), 32'(st));
    chk("R10", {tag, " busy"}, 32'(req_ready), 32'd0);
    chk("R8", {tag, " no early rsp"}, 32'(rsp_valid), 32'd0);
    if (st) begin
      ebe = '0; ewd = '0; mask = '0;
      for (int k = 0; k < n; k++) begin
        int ab = int'(a[1:0]) + k;
        int lane = big ? 3 - ab : ab;
        int di = big ? n - 1 - k : k;
        ebe[lane] = 1'b1;
        ewd[8*lane +: 8] = wd[8*di +: 8];
        mask[8*lane +: 8] = 8'hFF;
      end
      chk("R7", {tag, " mem_be"}, 32'(mem_be), 32'(ebe));
      chk("R7", {tag, " mem_wdata"}, mem_wdata & mask, ewd);
    end
    if (flip) cfg_big_endian = ~big;
    for (int i = 0; i < lat; i++) begin
      if (spurious && i == 0) begin
        if (st) begin mem_rvalid = 1'b1; mem_rdata = ~rd; end
        else mem_ack = 1'b1;
      end
      @(negedge clk);
      mem_rvalid = 1'b0; mem_ack = 1'b0;
      chk("R8", {tag, " strobe one cycle"}, 32'(mem_req), 32'd0);
      chk("R9", {tag, " waiting no rsp"}, 32'(rsp_valid), 32'd0);
      chk("R10", {tag, " still busy"}, 32'(req_ready), 32'd0);
    end
    if (st) mem_ack = 1'b1;
    else begin mem_rvalid = 1'b1; mem_rdata = rd; end
    @(negedge clk);
    mem_rvalid = 1'b0; mem_ack = 1'b0; mem_rdata = 32'hDEAD_BEEF;
    chk("R8", {tag, " rsp pulse"}, 32'(rsp_valid), 32'd1);
    chk("R2", {tag, " no err"}, 32'(rsp_err), 32'd0);
    chk("R10", {tag, " ready again"}, 32'(req_ready), 32'd1);
    if (!st) chk(tag, "load data", rsp_data, model_load(a, sz, sgn, big, rd));
    cfg_big_endian = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", "reset ready", 32'(req_ready), 32'd1);
    chk("R8", "reset rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R8", "reset mem_req", 32'(mem_req), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8", "after reset mem_req", 32'(mem_req), 32'd0);

    // little endian byte loads at each lane, signed selector ignored
    for (int k = 0; k < 4; k++)
      run_op("R3", 1'b0, 32'h2000 + 32'(k), 8'h00, 0, k[0], 1'b0, 0, 32'hC3A5_7E81, 1, 1'b0, 1'b0);
    run_op("R1", 1'b0, 32'h3000, 8'h05, 0, 1'b0, 1'b0, 0, 32'h1122_3344, 2, 1'b0, 1'b0);
    // halfword loads
    run_op("R4", 1'b0, 32'h4000, 8'h00, 1, 1'b1, 1'b0, 0, 32'h1234_F00D, 1, 1'b0, 1'b0);
    run_op("R4", 1'b0, 32'h4000, 8'h00, 1, 1'b0, 1'b0, 0, 32'h1234_F00D, 1, 1'b0, 1'b0);
    run_op("R4", 1'b0, 32'h4002, 8'h00, 1, 1'b1, 1'b0, 0, 32'h8001_7FFF, 1, 1'b0, 1'b0);
    run_op("R4", 1'b0, 32'h4000, 8'h00, 1, 1'b1, 1'b0, 0, 32'h8001_7FFF, 1, 1'b0, 1'b0);
    run_op("R1", 1'b0, 32'h4000, 8'h81, 1, 1'b1, 1'b0, 0, 32'hA5A5_9876, 1, 1'b0, 1'b0);
    // word loads, scaling and wrap
    run_op("R5", 1'b0, 32'h1000, 8'hFF, 2, 1'b0, 1'b0, 0, 32'h89AB_CDEF, 3, 1'b0, 1'b0);
    run_op("R1", 1'b0, 32'hFFFF_FFFC, 8'h01, 2, 1'b0, 1'b0, 0, 32'h0F0F_0F0F, 1, 1'b0, 1'b0);
    // big endian loads
    run_op("R6", 1'b0, 32'h6000, 8'h00, 0, 1'b0, 1'b1, 0, 32'hC3A5_7E81, 1, 1'b0, 1'b0);
    run_op("R6", 1'b0, 32'h6003, 8'h00, 0, 1'b0, 1'b1, 0, 32'hC3A5_7E81, 1, 1'b0, 1'b0);
    run_op("R6", 1'b0, 32'h6000, 8'h00, 1, 1'b1, 1'b1, 0, 32'h8001_7FFF, 1, 1'b0, 1'b0);
    run_op("R6", 1'b0, 32'h6002, 8'h00, 1, 1'b0, 1'b1, 0, 32'h8001_F7FF, 1, 1'b0, 1'b0);
    run_op("R5", 1'b0, 32'h6000, 8'h01, 2, 1'b0, 1'b1, 0, 32'h0123_4567, 1, 1'b0, 1'b0);
    // stores
    run_op("R7", 1'b1, 32'h7001, 8'h00, 0, 1'b0, 1'b0, 32'h0000_00A7, 0, 1, 1'b0, 1'b0);
    run_op("R7", 1'b1, 32'h7000, 8'h01, 1, 1'b0, 1'b0, 32'h0000_BEEF, 0, 2, 1'b0, 1'b0);
    run_op("R7", 1'b1, 32'h7000, 8'h02, 2, 1'b0, 1'b0, 32'hCAFE_F00D, 0, 1, 1'b0, 1'b0);
    run_op("R7", 1'b1, 32'h7000, 8'h00, 0, 1'b0, 1'b1, 32'h0000_005A, 0, 1, 1'b0, 1'b0);
    run_op("R7", 1'b1, 32'h7000, 8'h00, 1, 1'b0, 1'b1, 32'h0000_1357, 0, 1, 1'b0, 1'b0);
    run_op("R7", 1'b1, 32'h7000, 8'h00, 2, 1'b0, 1'b1, 32'h1234_5678, 0, 1, 1'b0, 1'b0);
    // misalignment
    run_op("R2", 1'b0, 32'h5001, 8'h00, 1, 1'b0, 1'b0, 0, 0, 1, 1'b0, 1'b0);
    run_op("R2", 1'b0, 32'h5002, 8'h00, 2, 1'b0, 1'b0, 0, 0, 1, 1'b0, 1'b0);
    run_op("R2", 1'b1, 32'h5003, 8'h04, 2, 1'b0, 1'b0, 32'hFFFF_FFFF, 0, 1, 1'b0, 1'b0);
    // wrong-type answers and endian change while outstanding
    run_op("R9", 1'b0, 32'h8000, 8'h00, 1, 1'b1, 1'b0, 0, 32'h0000_8765, 2, 1'b1, 1'b0);
    run_op("R9", 1'b1, 32'h8000, 8'h00, 2, 1'b0, 1'b0, 32'h5555_AAAA, 0, 3, 1'b1, 1'b0);
    run_op("R6", 1'b0, 32'h9000, 8'h00, 1, 1'b0, 1'b1, 0, 32'hABCD_1234, 2, 1'b0, 1'b1);
    // stray answers with nothing outstanding
    @(negedge clk);
    mem_rvalid = 1'b1; mem_ack = 1'b1; mem_rdata = 32'h1111_2222;
    @(negedge clk);
    mem_rvalid = 1'b0; mem_ack = 1'b0;
    chk("R9", "idle stray rsp", 32'(rsp_valid), 32'd0);
    chk("R9", "idle stray mem_req", 32'(mem_req), 32'd0);
    @(negedge clk);
    chk("R9", "idle stray later", 32'(rsp_valid), 32'd0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule